// File: doc/BRIEF.md
# Telephone Line Supervisory Controller

This block is the synchronous digital controller that sits beside the analog part of a subscriber line interface. The host gives it five active-low commands: loop power-down, feed polarity, ring request and two test-relay requests. The analog sense circuits give it three status inputs: an off-hook comparator on the loop current, a strobe that pulses when the ringing current crosses zero, and an 8-bit die-temperature code in degrees Celsius. Every asynchronous input passes through a two-flop synchronizer before the logic uses it. The zero-crossing strobe is also reduced to a one-cycle pulse on its rising edge.

Two state machines decide what the block does. The feed machine has four states. `FD_DOWN` is the powered-down loop, `FD_NORM` is normal polarity feed and `FD_REV` is reversed polarity feed. `FD_THERM` is thermal shutdown. Its transitions are:

- DOWN→NORM/REV when power-down is released; the polarity input picks which.
- NORM↔REV when polarity changes.
- NORM/REV→DOWN when power-down is asserted.
- Any state→THERM when the temperature reaches the trip point.
- THERM→DOWN/NORM/REV only when the temperature has fallen to the release point.

The ring machine also has four states. `RG_IDLE` means no ringing. `RG_RINGING` means the relay is energized. `RG_TRIP_PEND` means off-hook was seen while ringing and the block is waiting for a current zero. `RG_TRIPPED` means the trip is latched and the host has not yet acknowledged it. Its transitions are:

- IDLE→RINGING on a ring request while the loop is fed.
- RINGING→TRIP_PEND on off-hook.
- TRIP_PEND→TRIPPED on the zero-crossing pulse.
- RINGING/TRIP_PEND→IDLE when the request is withdrawn or the feed stops.
- TRIPPED→IDLE only when the ring request is withdrawn, which is the host's acknowledgment.

The block drives three open-drain-style active-low relay outputs, a 2-bit feed-mode code, an active-low off-hook indicator and an active-low thermal indicator.

Top module: `loop_supervisor`

## Requirements
- R1: While reset is asserted and after it is released with no stimulus, the feed code is 00 (powered down), all three relay outputs are high, and both indicator outputs are high.
- R2: When the power-down input is low, the feed code is 00 whatever the other inputs are, and the off-hook indicator stays high even if the loop is off-hook.
- R3: With power-down high, polarity high gives feed code 01 (normal) and polarity low gives feed code 10 (reversed), three clocks after the input changes.
- R4: In feed code 01 or 10 with no ringing in progress, the off-hook indicator equals the inverse of the off-hook comparator, two clocks late. This includes the silent part of a ring cadence, when the ring request is high.
- R5: A low ring request while the loop is fed drives the ring relay output low three clocks later.
- R6: Off-hook while the ring relay is energized leaves the relay energized and the off-hook indicator high until the next zero-crossing pulse. Three clocks after the strobe rises, the relay output goes high and the off-hook indicator goes low in the same cycle.
- R7: After a trip, the ring relay stays released and the off-hook indicator stays low while the ring request remains low, even if the loop goes back on-hook. The relay can be energized again only after the ring request has been high.
- R8: A temperature code at or above TRIP_C (default 150) gives feed code 00, a low thermal indicator, a low off-hook indicator and a released ring relay. A code of TRIP_C-1 does none of this.
- R9: Thermal shutdown persists for any code above RELEASE_C (default 140), and ends once the code is at or below RELEASE_C.
- R10: Each test relay output equals its own command input two clocks late, in every feed and ring state.
- R11: The ring relay is never energized while the feed code is 00. This covers both power-down and thermal shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_n_i | input | 1 | Loop power-down command, active low |
| polarity_i | input | 1 | Feed polarity: 1 normal, 0 reversed |
| ring_cmd_n_i | input | 1 | Ring request, active low |
| test_a_cmd_n_i | input | 1 | Test relay A request, active low |
| test_b_cmd_n_i | input | 1 | Test relay B request, active low |
| hook_det_i | input | 1 | Loop-current comparator, 1 = off-hook |
| zc_strobe_i | input | 1 | Ring-current zero-crossing strobe |
| die_temp_i | input | TEMP_W | Die temperature, unsigned degrees Celsius |
| ring_relay_n_o | output | 1 | Ring relay driver, low = energized |
| test_a_relay_n_o | output | 1 | Test relay A driver, low = energized |
| test_b_relay_n_o | output | 1 | Test relay B driver, low = energized |
| feed_mode_o | output | 2 | 00 down, 01 normal, 10 reversed |
| offhook_n_o | output | 1 | Off-hook indicator, active low |
| thermal_n_o | output | 1 | Thermal shutdown indicator, active low |

## Verification
A wrong feed state appears on `feed_mode_o` within one clock of the bad transition. A feed state that sticks in thermal shutdown or skips it shows on `thermal_n_o` at the boundary codes 149/150 and 141/140. A ring machine that trips early shows up as the relay releasing before the zero-crossing pulse has had time to arrive. One that fails to hold the trip latch shows up as the relay energizing again while the request is still low. Because the bench's reference model is compared on every clock, each of these errors is reported in the first cycle it becomes visible.

// File: rtl/slic_sup_pkg.sv
package slic_sup_pkg;

    typedef enum logic [1:0] {
        FD_DOWN  = 2'd0,
        FD_NORM  = 2'd1,
        FD_REV   = 2'd2,
        FD_THERM = 2'd3
    } feed_st_t;

    typedef enum logic [1:0] {
        RG_IDLE      = 2'd0,
        RG_RINGING   = 2'd1,
        RG_TRIP_PEND = 2'd2,
        RG_TRIPPED   = 2'd3
    } ring_st_t;

    localparam logic [1:0] FEED_CODE_DOWN = 2'b00;
    localparam logic [1:0] FEED_CODE_NORM = 2'b01;
    localparam logic [1:0] FEED_CODE_REV  = 2'b10;

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sup_thermal.sv
module sup_thermal #(
    parameter int TEMP_W    = 8,
    parameter int TRIP_C    = 150,
    parameter int RELEASE_C = 140
) (
    input  logic [TEMP_W-1:0] temp,
    output logic              over_trip,
    output logic              cooled
);
    localparam logic [TEMP_W-1:0] TRIP_CODE = TEMP_W'(TRIP_C);
    localparam logic [TEMP_W-1:0] REL_CODE  = TEMP_W'(RELEASE_C);

    assign over_trip = (temp >= TRIP_CODE);
    assign cooled    = (temp <= REL_CODE);
endmodule

// File: rtl/sup_feed_fsm.sv
module sup_feed_fsm
    import slic_sup_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pwr_on,
    input  logic     pol_norm,
    input  logic     over_trip,
    input  logic     cooled,
    output feed_st_t state
);
    feed_st_t nxt;
    feed_st_t live_sel;

    assign live_sel = !pwr_on ? FD_DOWN : (pol_norm ? FD_NORM : FD_REV);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FD_DOWN;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            FD_DOWN, FD_NORM, FD_REV: nxt = over_trip ? FD_THERM : live_sel;
            FD_THERM:                 nxt = cooled ? live_sel : FD_THERM;
            default:                  nxt = FD_DOWN;
        endcase
    end
endmodule

// File: rtl/sup_ring_fsm.sv
module sup_ring_fsm
    import slic_sup_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     feed_active,
    input  logic     ring_req,
    input  logic     hook,
    input  logic     zc_pulse,
    output ring_st_t state
);
    ring_st_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RG_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RG_IDLE:
                if (feed_active && ring_req) nxt = RG_RINGING;
            RG_RINGING:
                if (!feed_active || !ring_req) nxt = RG_IDLE;
                else if (hook)                 nxt = RG_TRIP_PEND;
            RG_TRIP_PEND:
                if (!feed_active || !ring_req) nxt = RG_IDLE;
                else if (zc_pulse)             nxt = RG_TRIPPED;
            RG_TRIPPED:
                if (!ring_req) nxt = RG_IDLE;
            default: nxt = RG_IDLE;
        endcase
    end
endmodule

// File: rtl/loop_supervisor.sv
module loop_supervisor
    import slic_sup_pkg::*;
#(
    parameter int TEMP_W      = 8,
    parameter int TRIP_C      = 150,
    parameter int RELEASE_C   = 140,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwrdn_n_i,
    input  logic              polarity_i,
    input  logic              ring_cmd_n_i,
    input  logic              test_a_cmd_n_i,
    input  logic              test_b_cmd_n_i,
    input  logic              hook_det_i,
    input  logic              zc_strobe_i,
    input  logic [TEMP_W-1:0] die_temp_i,
    output logic              ring_relay_n_o,
    output logic              test_a_relay_n_o,
    output logic              test_b_relay_n_o,
    output logic [1:0]        feed_mode_o,
    output logic              offhook_n_o,
    output logic              thermal_n_o
);
    localparam int CTL_W = 7;
    // bit order: pwrdn_n, polarity, ring_n, test_a_n, test_b_n, hook, zc
    localparam logic [CTL_W-1:0] CTL_RST = 7'b0_1_1_1_1_0_0;

    logic [CTL_W-1:0]  ctl_raw, ctl_s;
    logic [TEMP_W-1:0] temp_s;
    logic              pwr_on_s, pol_s, ring_req_s, ta_n_s, tb_n_s, hook_s, zc_s;
    logic              zc_prev, zc_pulse;
    logic              over_trip, cooled, feed_active;
    feed_st_t          feed_st;
    ring_st_t          ring_st;

    assign ctl_raw = {pwrdn_n_i, polarity_i, ring_cmd_n_i, test_a_cmd_n_i,
                      test_b_cmd_n_i, hook_det_i, zc_strobe_i};

    sup_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
    );

    sup_sync #(.WIDTH(TEMP_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_temp_sync (
        .clk(clk), .rst_n(rst_n), .d(die_temp_i), .q(temp_s)
    );

    assign pwr_on_s   = ctl_s[6];
    assign pol_s      = ctl_s[5];
    assign ring_req_s = ~ctl_s[4];
    assign ta_n_s     = ctl_s[3];
    assign tb_n_s     = ctl_s[2];
    assign hook_s     = ctl_s[1];
    assign zc_s       = ctl_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) zc_prev <= 1'b0;
        else        zc_prev <= zc_s;
    end
    assign zc_pulse = zc_s & ~zc_prev;

    sup_thermal #(.TEMP_W(TEMP_W), .TRIP_C(TRIP_C), .RELEASE_C(RELEASE_C)) u_thermal (
        .temp(temp_s), .over_trip(over_trip), .cooled(cooled)
    );

    sup_feed_fsm u_feed (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on_s), .pol_norm(pol_s),
        .over_trip(over_trip), .cooled(cooled), .state(feed_st)
    );

    assign feed_active = (feed_st == FD_NORM) || (feed_st == FD_REV);

    sup_ring_fsm u_ring (
        .clk(clk), .rst_n(rst_n), .feed_active(feed_active), .ring_req(ring_req_s),
        .hook(hook_s), .zc_pulse(zc_pulse), .state(ring_st)
    );

    always_comb begin
        test_a_relay_n_o = ta_n_s;
        test_b_relay_n_o = tb_n_s;
        thermal_n_o      = 1'b1;
        feed_mode_o      = FEED_CODE_DOWN;
        ring_relay_n_o   = 1'b1;
        offhook_n_o      = 1'b1;
        unique case (feed_st)
            FD_THERM: begin
                thermal_n_o = 1'b0;
                offhook_n_o = 1'b0;
            end
            FD_DOWN: ;
            FD_NORM, FD_REV: begin
                feed_mode_o = (feed_st == FD_NORM) ? FEED_CODE_NORM : FEED_CODE_REV;
                unique case (ring_st)
                    RG_RINGING, RG_TRIP_PEND: ring_relay_n_o = 1'b0;
                    RG_TRIPPED:               offhook_n_o    = 1'b0;
                    RG_IDLE:                  offhook_n_o    = ~hook_s;
                    default: ;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/loop_supervisor_checker.sv
module loop_supervisor_checker
    import slic_sup_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     test_a_cmd_n_i,
    input logic     test_b_cmd_n_i,
    input logic     ring_relay_n_o,
    input logic     test_a_relay_n_o,
    input logic     test_b_relay_n_o,
    input logic [1:0] feed_mode_o,
    input logic     offhook_n_o,
    input logic     thermal_n_o,
    input ring_st_t ring_st,
    input logic     ring_req_s,
    input logic     zc_pulse
);
    logic [1:0] up_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             up_cnt <= 2'd0;
        else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
    end

    p_down_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (feed_mode_o == 2'b00 && thermal_n_o) |-> offhook_n_o);

    p_therm_forces_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !thermal_n_o |-> (feed_mode_o == 2'b00 && !offhook_n_o && ring_relay_n_o));

    p_ring_needs_feed_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ring_relay_n_o |-> (feed_mode_o != 2'b00));

    p_ring_masks_hook_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ring_relay_n_o |-> offhook_n_o);

    p_trip_on_zc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ring_st) == RG_TRIP_PEND && ring_st == RG_TRIPPED) |-> $past(zc_pulse));

    p_rearm_needs_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ring_st) == RG_TRIPPED && ring_st != RG_TRIPPED) |-> !$past(ring_req_s));

    p_test_a_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt >= 2'd2) |-> (test_a_relay_n_o == $past(test_a_cmd_n_i, 2)));

    p_test_b_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt >= 2'd2) |-> (test_b_relay_n_o == $past(test_b_cmd_n_i, 2)));
endmodule

bind loop_supervisor loop_supervisor_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .test_a_cmd_n_i(test_a_cmd_n_i), .test_b_cmd_n_i(test_b_cmd_n_i),
    .ring_relay_n_o(ring_relay_n_o), .test_a_relay_n_o(test_a_relay_n_o),
    .test_b_relay_n_o(test_b_relay_n_o), .feed_mode_o(feed_mode_o),
    .offhook_n_o(offhook_n_o), .thermal_n_o(thermal_n_o),
    .ring_st(ring_st), .ring_req_s(ring_req_s), .zc_pulse(zc_pulse)
);

// File: tb/loop_supervisor_bench.sv
module loop_supervisor_bench;
    localparam int TRIP = 150;
    localparam int REL  = 140;
    localparam int M_DOWN = 0, M_NORM = 1, M_REV = 2, M_THERM = 3;
    localparam int R_IDLE = 0, R_ON = 1, R_PEND = 2, R_TRIP = 3;

    typedef struct packed {
        logic pw, pol, rg_n, ta_n, tb_n, hook, zc;
        logic [7:0] temp;
    } snap_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwrdn_n = 1'b0, pol = 1'b1, ring_n = 1'b1, ta_n = 1'b1, tb_n = 1'b1;
    logic hook = 1'b0, zc = 1'b0;
    logic [7:0] temp = 8'd25;
    logic ring_relay_n, ta_relay_n, tb_relay_n, offhook_n, thermal_n;
    logic [1:0] feed_mode;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    loop_supervisor u_loop_supervisor (
        .clk(clk), .rst_n(rst_n), .pwrdn_n_i(pwrdn_n), .polarity_i(pol),
        .ring_cmd_n_i(ring_n), .test_a_cmd_n_i(ta_n), .test_b_cmd_n_i(tb_n),
        .hook_det_i(hook), .zc_strobe_i(zc), .die_temp_i(temp),
        .ring_relay_n_o(ring_relay_n), .test_a_relay_n_o(ta_relay_n),
        .test_b_relay_n_o(tb_relay_n), .feed_mode_o(feed_mode),
        .offhook_n_o(offhook_n), .thermal_n_o(thermal_n)
    );

    // reference model: input history queue and two integer state variables
    snap_t hist[$];
    int m_feed = M_DOWN;
    int m_ring = R_IDLE;
    localparam snap_t RST_SNAP = '{pw:1'b0, pol:1'b1, rg_n:1'b1, ta_n:1'b1,
                                   tb_n:1'b1, hook:1'b0, zc:1'b0, temp:8'd0};

    function automatic snap_t now_snap();
        snap_t s;
        s.pw = pwrdn_n; s.pol = pol; s.rg_n = ring_n; s.ta_n = ta_n;
        s.tb_n = tb_n; s.hook = hook; s.zc = zc; s.temp = temp;
        return s;
    endfunction

    initial begin
        for (int i = 0; i < 3; i++) hist.push_back(RST_SNAP);
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist.delete();
            for (int i = 0; i < 3; i++) hist.push_back(RST_SNAP);
            m_feed = M_DOWN;
            m_ring = R_IDLE;
        end else begin
            snap_t s;
            snap_t p;
            int pick;
            int nf;
            int nr;
            bit act;
            bit zp;
            s = hist[1];
            p = hist[2];
            zp = s.zc && !p.zc;
            act = (m_feed == M_NORM) || (m_feed == M_REV);
            pick = !s.pw ? M_DOWN : (s.pol ? M_NORM : M_REV);
            if (m_feed == M_THERM) nf = (s.temp <= REL) ? pick : M_THERM;
            else                   nf = (s.temp >= TRIP) ? M_THERM : pick;
            nr = m_ring;
            if (m_ring == R_IDLE)      begin if (act && !s.rg_n) nr = R_ON; end
            else if (m_ring == R_TRIP) begin if (s.rg_n) nr = R_IDLE; end
            else if (!act || s.rg_n)   nr = R_IDLE;
            else if (m_ring == R_ON && s.hook) nr = R_PEND;
            else if (m_ring == R_PEND && zp)   nr = R_TRIP;
            m_feed = nf;
            m_ring = nr;
            hist.push_front(now_snap());
            void'(hist.pop_back());
        end
    end

    task automatic report(input bit ok, input string tag, input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            snap_t s;
            bit act;
            int e_feed;
            bit e_rr;
            bit e_oh;
            s = hist[1];
            act = (m_feed == M_NORM) || (m_feed == M_REV);
            e_feed = (m_feed == M_NORM) ? 1 : (m_feed == M_REV) ? 2 : 0;
            e_rr = !(act && (m_ring == R_ON || m_ring == R_PEND));
            if (m_feed == M_THERM)     e_oh = 1'b0;
            else if (!act)             e_oh = 1'b1;
            else if (m_ring == R_TRIP) e_oh = 1'b0;
            else if (m_ring != R_IDLE) e_oh = 1'b1;
            else                       e_oh = !s.hook;
            report(feed_mode == 2'(e_feed), "R3 feed_mode", feed_mode, e_feed);
            report(ring_relay_n == e_rr, "R6 ring_relay", ring_relay_n, e_rr);
            report(offhook_n == e_oh, "R4 offhook", offhook_n, e_oh);
            report(thermal_n == (m_feed != M_THERM), "R8 thermal", thermal_n, m_feed != M_THERM);
            report(ta_relay_n == s.ta_n, "R10 test_a", ta_relay_n, s.ta_n);
            report(tb_relay_n == s.tb_n, "R10 test_b", tb_relay_n, s.tb_n);
        end
    end

    task automatic wn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int a, input int e);
        report(ok, tag, a, e);
    endtask

    initial begin
        wn(3);
        // R1 during reset
        chk(feed_mode == 2'b00 && ring_relay_n && ta_relay_n && tb_relay_n, "R1 reset outputs",
            {feed_mode, ring_relay_n, ta_relay_n, tb_relay_n}, 4'b0011 << 0 | 4'b0111);
        chk(offhook_n && thermal_n, "R1 reset indicators", {offhook_n, thermal_n}, 3);
        rst_n = 1'b1;
        wn(6);
        chk(feed_mode == 2'b00 && ring_relay_n && offhook_n && thermal_n, "R1 after reset",
            feed_mode, 0);

        // R2: powered down ignores hook
        hook = 1'b1; pol = 1'b1;
        wn(6);
        chk(feed_mode == 2'b00, "R2 feed down", feed_mode, 0);
        chk(offhook_n == 1'b1, "R2 indicator disabled", offhook_n, 1);
        hook = 1'b0;

        // R3 normal
        pwrdn_n = 1'b1;
        wn(2);
        chk(feed_mode == 2'b00, "R3 latency before", feed_mode, 0);
        wn(1);
        chk(feed_mode == 2'b01, "R3 normal", feed_mode, 1);
        // R4
        hook = 1'b1;
        wn(1);
        chk(offhook_n == 1'b1, "R4 latency before", offhook_n, 1);
        wn(1);
        chk(offhook_n == 1'b0, "R4 offhook normal", offhook_n, 0);
        hook = 1'b0;
        wn(3);
        chk(offhook_n == 1'b1, "R4 onhook normal", offhook_n, 1);
        // R3 reversed
        pol = 1'b0;
        wn(6);
        chk(feed_mode == 2'b10, "R3 reversed", feed_mode, 2);
        hook = 1'b1;
        wn(3);
        chk(offhook_n == 1'b0, "R4 offhook reversed", offhook_n, 0);
        hook = 1'b0;
        wn(3);

        // R5 ring
        ring_n = 1'b0;
        wn(2);
        chk(ring_relay_n == 1'b1, "R5 latency before", ring_relay_n, 1);
        wn(1);
        chk(ring_relay_n == 1'b0, "R5 relay energized", ring_relay_n, 0);
        // R6 off-hook while ringing waits for zero crossing
        hook = 1'b1;
        wn(8);
        chk(ring_relay_n == 1'b0, "R6 held until zc", ring_relay_n, 0);
        chk(offhook_n == 1'b1, "R6 indicator masked", offhook_n, 1);
        zc = 1'b1;
        wn(1);
        zc = 1'b0;
        wn(1);
        chk(ring_relay_n == 1'b0, "R6 before zc pulse acts", ring_relay_n, 0);
        wn(1);
        chk(ring_relay_n == 1'b1, "R6 relay released at zc", ring_relay_n, 1);
        chk(offhook_n == 1'b0, "R6 indicator at zc", offhook_n, 0);

        // R7 latch until acknowledged
        hook = 1'b0;
        wn(8);
        chk(ring_relay_n == 1'b1, "R7 no re-ring before ack", ring_relay_n, 1);
        chk(offhook_n == 1'b0, "R7 trip latched", offhook_n, 0);
        ring_n = 1'b1;
        wn(6);
        chk(ring_relay_n == 1'b1 && offhook_n == 1'b1, "R7 acked", {ring_relay_n, offhook_n}, 3);
        ring_n = 1'b0;
        wn(6);
        chk(ring_relay_n == 1'b0, "R7 re-armed", ring_relay_n, 0);
        ring_n = 1'b1;
        wn(4);
        // R4 silent cadence off-hook
        hook = 1'b1;
        wn(3);
        chk(offhook_n == 1'b0, "R4 silent cadence offhook", offhook_n, 0);
        hook = 1'b0;
        wn(4);

        // R11 no ringing in power-down
        pwrdn_n = 1'b0; ring_n = 1'b0;
        wn(8);
        chk(ring_relay_n == 1'b1, "R11 no ring when down", ring_relay_n, 1);
        chk(feed_mode == 2'b00, "R2 down with ring req", feed_mode, 0);
        pwrdn_n = 1'b1;
        wn(6);
        chk(ring_relay_n == 1'b0, "R11 ring after power-up", ring_relay_n, 0);

        // R8 thermal with ringing active
        temp = 8'd149;
        wn(6);
        chk(thermal_n == 1'b1 && ring_relay_n == 1'b0, "R8 below trip", {thermal_n, ring_relay_n}, 2);
        temp = 8'd150;
        wn(6);
        chk(thermal_n == 1'b0, "R8 thermal trip", thermal_n, 0);
        chk(feed_mode == 2'b00 && offhook_n == 1'b0, "R8 forced down", {feed_mode, offhook_n}, 0);
        chk(ring_relay_n == 1'b1, "R11 ring released in thermal", ring_relay_n, 1);
        ring_n = 1'b1;
        // R10 in thermal
        ta_n = 1'b0;
        wn(1);
        chk(ta_relay_n == 1'b1, "R10 latency before", ta_relay_n, 1);
        wn(1);
        chk(ta_relay_n == 1'b0 && tb_relay_n == 1'b1, "R10 test_a in thermal", {ta_relay_n, tb_relay_n}, 1);
        // R9 hysteresis
        temp = 8'd141;
        wn(6);
        chk(thermal_n == 1'b0, "R9 still hot at 141", thermal_n, 0);
        temp = 8'd140;
        wn(6);
        chk(thermal_n == 1'b1 && feed_mode == 2'b10, "R9 released at 140", {thermal_n, feed_mode}, 6);
        temp = 8'd60;

        // R10 independence in powered-down
        pwrdn_n = 1'b0; tb_n = 1'b0; ta_n = 1'b1;
        wn(3);
        chk(ta_relay_n == 1'b1 && tb_relay_n == 1'b0, "R10 test_b while down", {ta_relay_n, tb_relay_n}, 2);
        tb_n = 1'b1;
        wn(3);
        chk(tb_relay_n == 1'b1, "R10 test_b released", tb_relay_n, 1);
        wn(4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule